// File: doc/BRIEF.md
# Half-Precision Fused Multiply-Subtract Lane Array

This block computes `acc - (a * b)` on IEEE half-precision operands with one rounding step. The sign of the first multiplicand is flipped, the product is kept exact, and it is added to the accumulator before the single final rounding. The block holds `LANES` identical 16-bit lanes. Eight lanes make a 128-bit register, and the low four lanes make a 64-bit register.

In scalar mode only lane 0 works. It follows the caller's rounding-mode, flush-to-zero and default-NaN controls, and its result also appears as a 32-bit register word with the upper half cleared. In vector mode every active lane ignores those controls and uses a fixed setting: round to nearest even, flush-to-zero on, default NaN on.

Results leave through a valid/ready handshake after a fixed two-cycle pipeline. Each result carries its own exception flags, and a sticky copy of the flags accumulates until reset.

Top module: `hfms_lanes`

## Requirements
- R1: Each active lane returns `acc + ((-a) * b)`. The product is exact and the sum is rounded once, so for acc=0x3C02, a=0x3C01, b=0x3C01 the result is 0x8010 and not zero.
- R2: In scalar mode `in_rmode` selects the rounding: 00 nearest-even, 01 toward +infinity, 10 toward -infinity, 11 toward zero. Any result that is not exact sets the inexact flag.
- R3: In vector mode `in_rmode`, `in_ftz` and `in_dnan` are ignored, and each lane uses nearest-even with flush-to-zero and default NaN. `in_quad`=0 enables lanes 0 to 3 and `in_quad`=1 enables all lanes. Disabled lanes return 0 and raise no flags.
- R4: In scalar mode only lane 0 (bits 15:0) is computed. All other `out_res` bits are 0, and `out_word` is `{16'h0000, lane 0 result}`.
- R5: With flush-to-zero, a denormal input counts as a zero of the same sign and sets input-denormal. A result that is tiny before rounding becomes a zero of the same sign and sets underflow only.
- R6: Infinity times zero returns 0x7E00 and sets invalid, even when the accumulator is a quiet NaN. An infinite product added to an infinite accumulator of opposite sign does the same.
- R7: With default NaN off, a NaN result is the first signalling NaN in the order acc, a, b, or if there is none the first quiet NaN in that order. It has bit 9 set, and a NaN taken from `a` has its sign flipped. Any signalling NaN sets invalid. With default NaN on, every NaN result is 0x7E00.
- R8: When two operands of opposite sign cancel exactly, the result is +0, except in round toward -infinity where it is -0. The sum of two zeros of the same sign keeps that sign.
- R9: On overflow the result is infinity or 0x7BFF (largest finite), chosen by rounding mode and sign, and both overflow and inexact are set. Without flush-to-zero, underflow is set when the result is tiny before rounding and also inexact.
- R10: Flag bits are: bit0 invalid, bit1 overflow, bit2 underflow, bit3 inexact, bit4 input-denormal. `out_flags` is the OR over active lanes for one result. `sticky_flags` accumulates every delivered result's flags until reset.
- R11: An accepted operation appears on `out_valid` two clock edges later. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the result and flags hold steady.
- R12: After reset `out_valid` is 0, `out_res` is 0, `sticky_flags` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted this cycle when high |
| in_vec | input | 1 | 1 = vector mode, 0 = scalar mode |
| in_quad | input | 1 | Vector width: 1 = 128-bit, 0 = 64-bit |
| in_rmode | input | 2 | Scalar rounding mode |
| in_ftz | input | 1 | Scalar flush-to-zero enable |
| in_dnan | input | 1 | Scalar default-NaN enable |
| in_acc | input | LANES*16 | Accumulator lanes |
| in_a | input | LANES*16 | First multiplicand lanes (negated) |
| in_b | input | LANES*16 | Second multiplicand lanes |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result taken this cycle when high |
| out_res | output | LANES*16 | Result lanes |
| out_word | output | 32 | Lane 0 result zero-extended to a 32-bit word |
| out_flags | output | 5 | Exception flags of the current result |
| sticky_flags | output | 5 | Accumulated exception flags |

## Verification
A fault in the stage-one magnitude or sign reaches `out_res` two edges after the operation is accepted. Cancellation cases and quarter-ulp or tie cases expose wrong alignment or rounding in the last bit. A mis-captured mode or lane mask shows up in the same result as nonzero bits in disabled lanes or as controls that were honoured when they should have been ignored. A corrupted flag register shows in `sticky_flags` on the very next delivered result, because bits there can only be added.

// File: rtl/hfms_pkg.sv
package hfms_pkg;
  localparam int HW  = 16;
  // exact fixed point: bit p weighs 2^(p-48); covers every product and accumulator
  localparam int FXW = 84;

  localparam int F_NV = 0;
  localparam int F_OF = 1;
  localparam int F_UF = 2;
  localparam int F_NX = 3;
  localparam int F_ID = 4;

  localparam logic [HW-1:0] QNAN_DEF = 16'h7E00;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_UP   = 2'b01,
    RM_DOWN = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef struct packed {
    logic           special;
    logic [HW-1:0]  spec_val;
    logic           sgn;
    logic [FXW-1:0] mag;
    logic [4:0]     flg;
    rmode_e         rm;
    logic           ftz;
  } mid_t;

  localparam mid_t MID_IDLE = '{special: 1'b1, rm: RM_NEAR, default: '0};
endpackage

// File: rtl/hfms_align.sv
module hfms_align
  import hfms_pkg::*;
(
  input  logic [HW-1:0] acc,
  input  logic [HW-1:0] a,
  input  logic [HW-1:0] b,
  input  rmode_e        rm,
  input  logic          ftz,
  input  logic          dnan,
  output mid_t          mid
);
  logic [HW-1:0] opv   [3];
  logic          nan_v [3];
  logic          snan_v[3];
  logic          inf_v [3];
  logic          zero_v[3];
  logic [10:0]   man_v [3];
  logic [4:0]    bex_v [3];
  logic          id_hit;

  // classify the three operands; index 1 already carries the flipped sign
  always_comb begin
    opv[0] = acc;
    opv[1] = {~a[15], a[14:0]};
    opv[2] = b;
    id_hit = 1'b0;
    for (int i = 0; i < 3; i++) begin
      nan_v[i]  = (&opv[i][14:10]) && (|opv[i][9:0]);
      snan_v[i] = nan_v[i] && !opv[i][9];
      inf_v[i]  = (&opv[i][14:10]) && !(|opv[i][9:0]);
      zero_v[i] = !(|opv[i][14:10]) && (!(|opv[i][9:0]) || ftz);
      man_v[i]  = (|opv[i][14:10]) ? {1'b1, opv[i][9:0]}
                                   : (ftz ? 11'd0 : {1'b0, opv[i][9:0]});
      bex_v[i]  = (|opv[i][14:10]) ? opv[i][14:10] : 5'd1;
      id_hit    = id_hit | (ftz && !(|opv[i][14:10]) && (|opv[i][9:0]));
    end
  end

  logic [21:0]    pm;
  logic [FXW-1:0] pfx, cfx;
  logic           sp, prod_inv, pinf, nan_any, snan_any;
  logic [HW-1:0]  pick;

  always_comb begin
    pm  = man_v[1] * man_v[2];
    pfx = FXW'(pm) << (7'(bex_v[1]) + 7'(bex_v[2]) - 7'd2);
    cfx = FXW'(man_v[0]) << (7'(bex_v[0]) + 7'd23);
    sp  = opv[1][15] ^ opv[2][15];
    prod_inv = (inf_v[1] && zero_v[2]) || (zero_v[1] && inf_v[2]);
    pinf     = inf_v[1] || inf_v[2];
    nan_any  = nan_v[0] || nan_v[1] || nan_v[2];
    snan_any = snan_v[0] || snan_v[1] || snan_v[2];
    if      (snan_v[0]) pick = opv[0];
    else if (snan_v[1]) pick = opv[1];
    else if (snan_v[2]) pick = opv[2];
    else if (nan_v[0])  pick = opv[0];
    else if (nan_v[1])  pick = opv[1];
    else                pick = opv[2];

    mid          = MID_IDLE;
    mid.special  = 1'b0;
    mid.rm       = rm;
    mid.ftz      = ftz;
    mid.flg[F_ID] = id_hit;

    // exact signed-magnitude sum
    if (sp == opv[0][15]) begin
      mid.mag = pfx + cfx;  mid.sgn = sp;
    end else if (pfx > cfx) begin
      mid.mag = pfx - cfx;  mid.sgn = sp;
    end else if (cfx > pfx) begin
      mid.mag = cfx - pfx;  mid.sgn = opv[0][15];
    end else begin
      mid.mag = '0;         mid.sgn = (rm == RM_DOWN);
    end

    if (nan_any) begin
      mid.special   = 1'b1;
      mid.spec_val  = dnan ? QNAN_DEF : (pick | 16'h0200);
      mid.flg[F_NV] = snan_any;
      if (nan_v[0] && !snan_v[0] && prod_inv) begin
        mid.spec_val  = QNAN_DEF;
        mid.flg[F_NV] = 1'b1;
      end
    end else if (prod_inv || (pinf && inf_v[0] && (sp != opv[0][15]))) begin
      mid.special   = 1'b1;
      mid.spec_val  = QNAN_DEF;
      mid.flg[F_NV] = 1'b1;
    end else if (pinf) begin
      mid.special  = 1'b1;
      mid.spec_val = {sp, 15'h7C00};
    end else if (inf_v[0]) begin
      mid.special  = 1'b1;
      mid.spec_val = {opv[0][15], 15'h7C00};
    end
  end
endmodule

// File: rtl/hfms_round.sv
module hfms_round
  import hfms_pkg::*;
(
  input  mid_t          mid,
  output logic [HW-1:0] res,
  output logic [4:0]    flg
);
  logic [6:0]  lead, lsb;
  logic [10:0] kept;
  logic        grd, stk, up, tiny, ovf, to_inf;
  logic [15:0] pk;

  always_comb begin
    lead = '0;
    for (int i = 0; i < FXW; i++)
      if (mid.mag[i]) lead = 7'(i);
    tiny = (lead < 7'd34);
    lsb  = tiny ? 7'd24 : (lead - 7'd10);
    kept = 11'(mid.mag >> lsb);
    grd  = mid.mag[lsb - 7'd1];
    stk  = |(mid.mag & ((FXW'(1) << (lsb - 7'd1)) - FXW'(1)));
    case (mid.rm)
      RM_NEAR: up = grd && (stk || kept[0]);
      RM_UP:   up = !mid.sgn && (grd || stk);
      RM_DOWN: up = mid.sgn && (grd || stk);
      default: up = 1'b0;
    endcase
    // exponent field plus significand; a carry walks into the exponent
    pk  = (tiny ? 16'd0 : (16'(lead - 7'd34) << 10)) + {5'd0, kept} + {15'd0, up};
    ovf = (pk >= 16'h7C00);
    to_inf = (mid.rm == RM_NEAR) || ((mid.rm == RM_UP) && !mid.sgn) ||
             ((mid.rm == RM_DOWN) && mid.sgn);

    flg = mid.flg;
    if (mid.special) begin
      res = mid.spec_val;
    end else if (mid.mag == '0) begin
      res = {mid.sgn, 15'd0};
    end else if (mid.ftz && tiny) begin
      res = {mid.sgn, 15'd0};
      flg[F_UF] = 1'b1;
    end else if (ovf) begin
      res = {mid.sgn, to_inf ? 15'h7C00 : 15'h7BFF};
      flg[F_OF] = 1'b1;
      flg[F_NX] = 1'b1;
    end else begin
      res = {mid.sgn, pk[14:0]};
      flg[F_NX] = grd || stk;
      flg[F_UF] = tiny && (grd || stk);
    end
  end
endmodule

// File: rtl/hfms_lanes.sv
module hfms_lanes
  import hfms_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_vec,
  input  logic                in_quad,
  input  logic [1:0]          in_rmode,
  input  logic                in_ftz,
  input  logic                in_dnan,
  input  logic [LANES*16-1:0] in_acc,
  input  logic [LANES*16-1:0] in_a,
  input  logic [LANES*16-1:0] in_b,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANES*16-1:0] out_res,
  output logic [31:0]         out_word,
  output logic [4:0]          out_flags,
  output logic [4:0]          sticky_flags
);
  localparam int VW   = LANES * HW;
  localparam int HALF = LANES / 2;

  logic          adv, s1_v, s1_vec, out_vec;
  rmode_e        rm_sel;
  logic          ftz_sel, dn_sel;
  logic [VW-1:0] lane_res;
  logic [4:0]    lane_flg [LANES];
  logic [4:0]    flg_or;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign rm_sel   = in_vec ? RM_NEAR : rmode_e'(in_rmode);
  assign ftz_sel  = in_vec | in_ftz;
  assign dn_sel   = in_vec | in_dnan;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    mid_t          mid_c, mid_q;
    logic          act;
    logic [HW-1:0] r_c;
    logic [4:0]    f_c;

    assign act = in_vec ? (in_quad || (g < HALF)) : (g == 0);

    hfms_align u_align (
      .acc (in_acc[g*HW +: HW]),
      .a   (in_a[g*HW +: HW]),
      .b   (in_b[g*HW +: HW]),
      .rm  (rm_sel),
      .ftz (ftz_sel),
      .dnan(dn_sel),
      .mid (mid_c)
    );

    always_ff @(posedge clk)
      if (adv && in_valid) mid_q <= act ? mid_c : MID_IDLE;

    hfms_round u_round (
      .mid(mid_q),
      .res(r_c),
      .flg(f_c)
    );

    assign lane_res[g*HW +: HW] = r_c;
    assign lane_flg[g]          = f_c;
  end

  always_comb begin
    flg_or = '0;
    for (int i = 0; i < LANES; i++) flg_or = flg_or | lane_flg[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v         <= 1'b0;
      s1_vec       <= 1'b0;
      out_valid    <= 1'b0;
      out_vec      <= 1'b0;
      out_res      <= '0;
      out_flags    <= '0;
      sticky_flags <= '0;
    end else if (adv) begin
      s1_v      <= in_valid;
      if (in_valid) s1_vec <= in_vec;
      out_valid <= s1_v;
      if (s1_v) begin
        out_res      <= lane_res;
        out_flags    <= flg_or;
        out_vec      <= s1_vec;
        sticky_flags <= sticky_flags | flg_or;
      end
    end
  end

  assign out_word = {16'h0000, out_res[HW-1:0]};

  // R11: accepted work shows up two edges later
  a_r11_two_edges: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> ##1 out_valid);

  // R11: a stalled result holds
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_flags)));

  // R10: sticky bits never drop
  a_r10_sticky_keep: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sticky_flags & $past(sticky_flags)) == $past(sticky_flags)));

  // R4: scalar results leave the upper lanes clear
  a_r4_scalar_upper: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_vec) |-> (out_res[VW-1:HW] == '0));

  // R3: vector lane 0 NaN results are canonical
  a_r3_vec_nan: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_vec && (&out_res[14:10]) && (|out_res[9:0])) |-> (out_res[HW-1:0] == QNAN_DEF));

  // R5: vector lane 0 never delivers a denormal
  a_r5_vec_nodenorm: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_vec) |-> !((out_res[14:10] == 5'd0) && (out_res[9:0] != 10'd0)));
endmodule

// File: tb/hfms_lanes_tb_top.sv
module hfms_lanes_tb_top;
  localparam int LANES = 8;
  localparam int VW    = LANES * 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0, in_vec = 1'b0, in_quad = 1'b0, in_ftz = 1'b0, in_dnan = 1'b0;
  logic [1:0]    in_rmode = 2'b00;
  logic [VW-1:0] in_acc = '0, in_a = '0, in_b = '0;
  logic          out_ready = 1'b1;
  logic          in_ready, out_valid;
  logic [VW-1:0] out_res;
  logic [31:0]   out_word;
  logic [4:0]    out_flags, sticky_flags;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  hfms_lanes #(.LANES(LANES)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_vec(in_vec), .in_quad(in_quad), .in_rmode(in_rmode), .in_ftz(in_ftz),
    .in_dnan(in_dnan), .in_acc(in_acc), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
    .out_word(out_word), .out_flags(out_flags), .sticky_flags(sticky_flags)
  );

  task automatic chk(input string req, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  // issue one operation, wait the two edges, sample between edges
  task automatic run_op(input logic vec, input logic quad, input logic [1:0] rm,
                        input logic ftz, input logic dn,
                        input logic [VW-1:0] acc, input logic [VW-1:0] a, input logic [VW-1:0] b);
    @(negedge clk);
    in_vec = vec; in_quad = quad; in_rmode = rm; in_ftz = ftz; in_dnan = dn;
    in_acc = acc; in_a = a; in_b = b; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R11 latency", VW'(out_valid), VW'(1));
  endtask

  task automatic scalar(input string req, input logic [1:0] rm, input logic ftz, input logic dn,
                        input logic [15:0] acc, input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] exp_r, input logic [4:0] exp_f);
    run_op(1'b0, 1'b0, rm, ftz, dn, VW'(acc), VW'(a), VW'(b));
    chk(req, out_res, VW'(exp_r));
    chk({req, " flags R10"}, VW'(out_flags), VW'(exp_f));
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R12 valid", VW'(out_valid), VW'(0));
    chk("R12 res", out_res, '0);
    chk("R12 sticky", VW'(sticky_flags), VW'(0));
    chk("R12 ready", VW'(in_ready), VW'(1));
  endtask

  task automatic t_basic();
    scalar("R1 3-1*2", 2'b00, 1'b0, 1'b0, 16'h4200, 16'h3C00, 16'h4000, 16'h3C00, 5'h00);
    scalar("R1 1-2*3", 2'b00, 1'b0, 1'b0, 16'h3C00, 16'h4000, 16'h4200, 16'hC500, 5'h00);
    scalar("R1 fused", 2'b00, 1'b0, 1'b0, 16'h3C02, 16'h3C01, 16'h3C01, 16'h8010, 5'h00);
  endtask

  task automatic t_rounding();
    scalar("R2 near", 2'b00, 1'b0, 1'b0, 16'h3C00, 16'h8C00, 16'h3C00, 16'h3C00, 5'h08);
    scalar("R2 up",   2'b01, 1'b0, 1'b0, 16'h3C00, 16'h8C00, 16'h3C00, 16'h3C01, 5'h08);
    scalar("R2 down", 2'b10, 1'b0, 1'b0, 16'h3C00, 16'h8C00, 16'h3C00, 16'h3C00, 5'h08);
    scalar("R2 zero", 2'b11, 1'b0, 1'b0, 16'h3C00, 16'h8C00, 16'h3C00, 16'h3C00, 5'h08);
    scalar("R2 down neg", 2'b10, 1'b0, 1'b0, 16'hBC00, 16'h0C00, 16'h3C00, 16'hBC01, 5'h08);
    scalar("R2 up neg",   2'b01, 1'b0, 1'b0, 16'hBC00, 16'h0C00, 16'h3C00, 16'hBC00, 5'h08);
    scalar("R2 tie even", 2'b00, 1'b0, 1'b0, 16'h3C01, 16'h9000, 16'h3C00, 16'h3C02, 5'h08);
  endtask

  task automatic t_overflow_underflow();
    scalar("R9 ovf near", 2'b00, 1'b0, 1'b0, 16'h7BFF, 16'hF800, 16'h3C00, 16'h7C00, 5'h0A);
    scalar("R9 ovf zero", 2'b11, 1'b0, 1'b0, 16'h7BFF, 16'hF800, 16'h3C00, 16'h7BFF, 5'h0A);
    scalar("R9 ovf down", 2'b10, 1'b0, 1'b0, 16'h7BFF, 16'hF800, 16'h3C00, 16'h7BFF, 5'h0A);
    scalar("R9 uf near",  2'b00, 1'b0, 1'b0, 16'h0000, 16'h0001, 16'h3800, 16'h8000, 5'h0C);
    scalar("R9 uf down",  2'b10, 1'b0, 1'b0, 16'h0000, 16'h0001, 16'h3800, 16'h8001, 5'h0C);
  endtask

  task automatic t_flush();
    scalar("R5 in denorm", 2'b00, 1'b1, 1'b0, 16'h3C00, 16'h0001, 16'h3C00, 16'h3C00, 5'h10);
    scalar("R5 out tiny",  2'b00, 1'b1, 1'b0, 16'h0000, 16'h0400, 16'h3800, 16'h8000, 5'h04);
    scalar("R5 no ftz",    2'b00, 1'b0, 1'b0, 16'h0000, 16'h0400, 16'h3800, 16'h8200, 5'h00);
  endtask

  task automatic t_invalid();
    scalar("R6 inf*0 qnan", 2'b00, 1'b0, 1'b0, 16'h7E01, 16'h7C00, 16'h0000, 16'h7E00, 5'h01);
    scalar("R6 inf-inf",    2'b00, 1'b0, 1'b0, 16'h7C00, 16'h7C00, 16'h3C00, 16'h7E00, 5'h01);
    scalar("R6 inf+inf",    2'b00, 1'b0, 1'b0, 16'h7C00, 16'hFC00, 16'h3C00, 16'h7C00, 5'h00);
  endtask

  task automatic t_nan();
    scalar("R7 snan a",    2'b00, 1'b0, 1'b0, 16'h7E05, 16'h7C03, 16'h3C00, 16'hFE03, 5'h01);
    scalar("R7 snan b",    2'b00, 1'b0, 1'b0, 16'h7E05, 16'h7E07, 16'h7D00, 16'h7F00, 5'h01);
    scalar("R7 qnan acc",  2'b00, 1'b0, 1'b0, 16'h7E05, 16'h7E07, 16'h3C00, 16'h7E05, 5'h00);
    scalar("R7 qnan a",    2'b00, 1'b0, 1'b0, 16'h3C00, 16'h7E07, 16'h3C00, 16'hFE07, 5'h00);
    scalar("R7 default",   2'b00, 1'b0, 1'b1, 16'h7E05, 16'h3C00, 16'h3C00, 16'h7E00, 5'h00);
  endtask

  task automatic t_zero_sign();
    scalar("R8 cancel near", 2'b00, 1'b0, 1'b0, 16'h4000, 16'h3C00, 16'h4000, 16'h0000, 5'h00);
    scalar("R8 cancel down", 2'b10, 1'b0, 1'b0, 16'h4000, 16'h3C00, 16'h4000, 16'h8000, 5'h00);
    scalar("R8 neg zeros",   2'b00, 1'b0, 1'b0, 16'h8000, 16'h0000, 16'h3C00, 16'h8000, 5'h00);
  endtask

  task automatic t_scalar_word();
    logic [VW-1:0] acc, a, b;
    acc = {{7{16'h7C01}}, 16'h4200};
    a   = {{7{16'h3C00}}, 16'h3C00};
    b   = {{7{16'h3C00}}, 16'h4000};
    run_op(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, acc, a, b);
    chk("R4 upper lanes", out_res, VW'(16'h3C00));
    chk("R4 word", VW'(out_word), VW'(32'h0000_3C00));
    chk("R4 flags", VW'(out_flags), VW'(0));
  endtask

  task automatic t_vector();
    logic [VW-1:0] acc, a, b;
    // 64-bit: controls ask for round-up, no flush, no default NaN: all ignored
    acc = {{4{16'h7C01}}, 16'h4200, 16'h3C00, 16'h7E05, 16'h3C00};
    a   = {{4{16'h3C00}}, 16'h3C00, 16'h0001, 16'h3C00, 16'h8C00};
    b   = {{4{16'h3C00}}, 16'h4000, 16'h3C00, 16'h3C00, 16'h3C00};
    run_op(1'b1, 1'b0, 2'b01, 1'b0, 1'b0, acc, a, b);
    chk("R3 vec64 res", out_res, {64'h0, 16'h3C00, 16'h3C00, 16'h7E00, 16'h3C00});
    chk("R3 vec64 flags", VW'(out_flags), VW'(5'h18));
    chk("R4 vec word", VW'(out_word), VW'(32'h0000_3C00));
    // 128-bit: lane 6 has a tiny result that vector mode flushes
    acc = {16'h3C00, 16'h3C02, {6{16'h4200}}};
    a   = {16'h4000, 16'h3C01, {6{16'h3C00}}};
    b   = {16'h4200, 16'h3C01, {6{16'h4000}}};
    run_op(1'b1, 1'b1, 2'b11, 1'b0, 1'b0, acc, a, b);
    chk("R3 vec128 res", out_res, {16'hC500, 16'h8000, {6{16'h3C00}}});
    chk("R3 vec128 flags", VW'(out_flags), VW'(5'h04));
  endtask

  task automatic t_sticky();
    do_reset();
    scalar("R10 first", 2'b00, 1'b0, 1'b0, 16'h3C00, 16'h8C00, 16'h3C00, 16'h3C00, 5'h08);
    scalar("R10 second", 2'b00, 1'b0, 1'b0, 16'h3C00, 16'h7C00, 16'h0000, 16'h7E00, 5'h01);
    chk("R10 sticky", VW'(sticky_flags), VW'(5'h09));
  endtask

  task automatic t_stall();
    logic [VW-1:0] held;
    @(negedge clk); out_ready = 1'b0;
    run_op(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, VW'(16'h3C00), VW'(16'h4000), VW'(16'h4200));
    held = out_res;
    chk("R11 stall res", held, VW'(16'hC500));
    chk("R11 ready low", VW'(in_ready), VW'(0));
    repeat (3) @(negedge clk);
    chk("R11 still valid", VW'(out_valid), VW'(1));
    chk("R11 held", out_res, held);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R11 drained", VW'(out_valid), VW'(0));
    chk("R11 ready back", VW'(in_ready), VW'(1));
  endtask

  initial begin
    t_reset();
    t_basic();
    t_rounding();
    t_overflow_underflow();
    t_flush();
    t_invalid();
    t_nan();
    t_zero_sign();
    t_scalar_word();
    t_vector();
    t_sticky();
    t_stall();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R11 got=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule